// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter for Sixteen Masters

This block decides which of sixteen masters owns a shared pipelined system bus. Every master raises a request line and may raise a lock line. On each transfer boundary the arbiter hands the bus to the next requester in a rotating order, which prevents any requester from being starved. A master that holds its lock line keeps the bus for as long as the lock stays high. When nothing is requested, the bus parks on master 0.

The arbiter watches the transfer type, burst type, ready, response and split-resume inputs. A small Gray-coded controller with a beat counter holds ownership steady through fixed-length bursts. A master that receives a SPLIT response is taken out of contention until the slave resumes it. The outputs are a one-hot grant vector, a registered owner number and a registered lock flag. These are plain control pins with no streaming handshake. Ownership changes in one clock edge, on a cycle with ready high.

Top module: `ahb_rr_arbiter`

## Requirements
- R1: Exactly one grant bit is high at any time, and it is the bit indexed by `master_id`.
- R2: At a handover, the search for a new owner starts at the master just after the last one granted and wraps from 15 to 0. The first requesting, unmasked master wins.
- R3: While the current owner holds its `lock` bit on a ready cycle, ownership does not change. The only exception is a SPLIT response (`hresp` = 2'b11) in that cycle.
- R4: At a handover where no eligible master requests, `master_id` becomes 0.
- R5: On every cycle with `hready` high, `mastlock` is loaded with the `lock` bit of the master that owns the bus after that edge. It holds its value when `hready` is low.
- R6: `master_id` and `grant` change only at a clock edge where `hready` is high.
- R7: In a fixed burst (`hburst[2:1]` = 01 for 4 beats, 10 for 8 beats, 11 for 16 beats), ready beats are counted. A NONSEQ beat (`htrans` = 2'b10) is beat 1 and each SEQ beat (2'b11) adds one. Handover happens only on the ready final beat. Single and incrementing bursts (`hburst[2:1]` = 00) allow a handover on every ready beat.
- R8: An IDLE transfer (`htrans` = 2'b00) on a ready cycle ends a burst early and allows a handover.
- R9: A SPLIT response on a ready cycle forces a handover away from the owner and masks that master. The mask ignores the lock. A set bit of `hsplit` unmasks its master in the same cycle, so the master can win that cycle. Master 0 is never masked.
- R10: After reset, `master_id` is 0, `grant` is 16'h0001 and `mastlock` is 0. The first clock edge after reset performs no handover, and the rotation then starts its search at master 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req | input | 16 | Request line per master |
| lock | input | 16 | Lock line per master |
| htrans | input | 2 | Transfer type: 00 idle, 01 busy, 10 nonseq, 11 seq |
| hburst | input | 3 | Burst type; bits 2:1 select single/incr, 4, 8 or 16 beats |
| hready | input | 1 | Transfer completes this cycle |
| hresp | input | 2 | Slave response; 2'b11 is SPLIT |
| hsplit | input | 16 | Split-resume bit per master |
| grant | output | 16 | One-hot grant per master |
| master_id | output | 4 | Number of the current owner |
| mastlock | output | 1 | The current owner holds a lock |

## Verification
The interesting collision is a lock held by the owner and a SPLIT response in the same ready cycle. The bench provokes it by giving master 3 both its lock bit and a SPLIT response while master 5 requests. It expects ownership to move to 5 with `mastlock` cleared, and it then expects master 3 to stay out of contention until its `hsplit` bit rises. A second collision puts the final beat of a 4-beat burst in the same cycle as a waiting rival. The bench judges that case by checking that ownership is steady through the earlier beats, including a stalled one, and moves exactly on the fourth ready beat.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int BEAT_W = 5;

  typedef enum logic [1:0] {
    ST_START = 2'b00,
    ST_CHECK = 2'b01,
    ST_BURST = 2'b11
  } ctrl_st_e;

  localparam logic [1:0] TR_IDLE  = 2'b00;
  localparam logic [1:0] TR_NSEQ  = 2'b10;
  localparam logic [1:0] TR_SEQ   = 2'b11;
  localparam logic [1:0] RSP_SPLT = 2'b11;

  function automatic logic [BEAT_W-1:0] beats_of(input logic [2:0] kind);
    case (kind[2:1])
      2'b01:   beats_of = BEAT_W'(4);
      2'b10:   beats_of = BEAT_W'(8);
      2'b11:   beats_of = BEAT_W'(16);
      default: beats_of = BEAT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] htrans,
  input  logic [2:0] hburst,
  input  logic       hready,
  output logic       live,
  output logic       xfer_end
);
  ctrl_st_e          st_q, st_d;
  logic [BEAT_W-1:0] cnt_q, len, beats_now;
  logic              at_end;

  assign len       = beats_of(hburst);
  assign beats_now = (htrans == TR_NSEQ) ? BEAT_W'(1) : cnt_q + BEAT_W'(1);
  assign at_end    = (htrans == TR_IDLE) || (htrans[1] && (beats_now >= len));
  assign live      = (st_q != ST_START);
  assign xfer_end  = live && at_end;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_START: st_d = ST_CHECK;
      ST_CHECK: if (hready && htrans[1] && !at_end) st_d = ST_BURST;
      ST_BURST: if (hready && at_end) st_d = ST_CHECK;
      default:  st_d = ST_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_START;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (!live) cnt_q <= '0;
      else if (hready) begin
        if (at_end)                cnt_q <= '0;
        else if (htrans == TR_NSEQ) cnt_q <= BEAT_W'(1);
        else if (htrans == TR_SEQ)  cnt_q <= cnt_q + BEAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
  parameter int NUM_M = 16,
  localparam int ID_W = $clog2(NUM_M)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [ID_W-1:0]  owner,
  input  logic [NUM_M-1:0] resume,
  output logic [NUM_M-1:0] blocked
);
  logic [NUM_M-1:0] mask_q;

  for (genvar i = 0; i < NUM_M; i++) begin : g_bit
    if (i == 0) begin : g_dflt
      assign mask_q[i] = 1'b0;
    end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            mask_q[i] <= 1'b0;
        else if (hit && owner == ID_W'(i))     mask_q[i] <= 1'b1;
        else if (resume[i])                    mask_q[i] <= 1'b0;
      end
    end
    assign blocked[i] = mask_q[i] & ~resume[i];
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_M = 16,
  localparam int ID_W = $clog2(NUM_M)
) (
  input  logic [NUM_M-1:0] elig,
  input  logic [ID_W-1:0]  start,
  output logic             any,
  output logic [ID_W-1:0]  win
);
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int k = 0; k < NUM_M; k++) begin
      logic [ID_W:0] j;
      j = {1'b0, start} + (ID_W+1)'(k);
      if (j >= (ID_W+1)'(NUM_M)) j = j - (ID_W+1)'(NUM_M);
      if (!any && elig[j[ID_W-1:0]]) begin
        any = 1'b1;
        win = j[ID_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ahb_rr_arbiter.sv
module ahb_rr_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_M = 16,
  localparam int ID_W = $clog2(NUM_M)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_M-1:0] req,
  input  logic [NUM_M-1:0] lock,
  input  logic [1:0]       htrans,
  input  logic [2:0]       hburst,
  input  logic             hready,
  input  logic [1:0]       hresp,
  input  logic [NUM_M-1:0] hsplit,
  output logic [NUM_M-1:0] grant,
  output logic [ID_W-1:0]  master_id,
  output logic             mastlock
);
  logic [ID_W-1:0]  owner_q, ptr_q, win, next_id;
  logic [NUM_M-1:0] blocked, cut, elig;
  logic             arb_live, xfer_end, split_now, any, go, lock_q;

  arb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .htrans(htrans), .hburst(hburst),
    .hready(hready), .live(arb_live), .xfer_end(xfer_end)
  );

  assign split_now = hready && (hresp == RSP_SPLT);

  arb_split_mask #(.NUM_M(NUM_M)) u_mask (
    .clk(clk), .rst_n(rst_n), .hit(split_now), .owner(owner_q),
    .resume(hsplit), .blocked(blocked)
  );

  for (genvar i = 0; i < NUM_M; i++) begin : g_cut
    if (i == 0) begin : g_zero
      assign cut[i] = 1'b0;
    end else begin : g_own
      assign cut[i] = split_now && (owner_q == ID_W'(i));
    end
  end

  assign elig = req & ~blocked & ~cut;

  arb_rr_pick #(.NUM_M(NUM_M)) u_pick (
    .elig(elig), .start(ptr_q), .any(any), .win(win)
  );

  assign go      = hready && arb_live && (split_now || (xfer_end && !lock[owner_q]));
  assign next_id = go ? (any ? win : '0) : owner_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      ptr_q   <= ID_W'(1);
      lock_q  <= 1'b0;
    end else begin
      if (go) begin
        owner_q <= next_id;
        ptr_q   <= (next_id == ID_W'(NUM_M-1)) ? '0 : next_id + ID_W'(1);
      end
      if (hready) lock_q <= lock[next_id];
    end
  end

  for (genvar i = 0; i < NUM_M; i++) begin : g_gnt
    assign grant[i] = (owner_q == ID_W'(i));
  end

  assign master_id = owner_q;
  assign mastlock  = lock_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_M = 16,
  localparam int ID_W = $clog2(NUM_M)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_M-1:0] req,
  input logic [NUM_M-1:0] lock,
  input logic [1:0]       htrans,
  input logic             hready,
  input logic [1:0]       hresp,
  input logic [ID_W-1:0]  master_id,
  input logic             mastlock,
  input logic             arb_live
);
  logic [NUM_M-1:0] lock_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_d <= '0;
    else        lock_d <= lock;
  end

  a_r6_hold_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> $stable(master_id));

  a_r3_lock_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && lock[master_id] && hresp != 2'b11) |=> $stable(master_id));

  a_r4_park_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && arb_live && req == '0 && !lock[master_id] && htrans == 2'b00
     && hresp != 2'b11) |=> master_id == '0);

  a_r5_lock_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hready |=> mastlock == lock_d[master_id]);

  a_r9_split_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && arb_live && hresp == 2'b11 && master_id != '0)
    |=> master_id != $past(master_id));
endmodule

bind ahb_rr_arbiter arb_checker #(.NUM_M(NUM_M)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .htrans(htrans),
  .hready(hready), .hresp(hresp), .master_id(master_id),
  .mastlock(mastlock), .arb_live(arb_live)
);

// File: tb/ahb_rr_arbiter_tb.sv
`timescale 1ns/1ps
module ahb_rr_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0, lock = '0, hsplit = '0;
  logic [1:0]  htrans = 2'b00, hresp = 2'b00;
  logic [2:0]  hburst = 3'b000;
  logic        hready = 1'b1;
  logic [15:0] grant;
  logic [3:0]  master_id;
  logic        mastlock;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { logic [3:0] id; logic ml; string tag; } exp_t;
  exp_t sb[$];
  exp_t e;

  always #2.5 clk = ~clk;

  ahb_rr_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .htrans(htrans),
    .hburst(hburst), .hready(hready), .hresp(hresp), .hsplit(hsplit),
    .grant(grant), .master_id(master_id), .mastlock(mastlock)
  );

  task automatic check(input string tag, input logic [3:0] id, input logic ml);
    total++;
    if (master_id !== id || mastlock !== ml || grant !== (16'h1 << id)) begin
      bad++;
      $display("FAIL %s: id=%0d ml=%0b grant=%h expected id=%0d ml=%0b grant=%h",
               tag, master_id, mastlock, grant, id, ml, 16'h1 << id);
    end
  endtask

  task automatic apply(input logic [15:0] r, input logic [15:0] l,
                       input logic [1:0] tr, input logic [2:0] bu,
                       input logic rdy, input logic [1:0] rs, input logic [15:0] sp,
                       input logic [3:0] id, input logic ml, input string tag);
    req = r; lock = l; htrans = tr; hburst = bu; hready = rdy; hresp = rs; hsplit = sp;
    sb.push_back('{id: id, ml: ml, tag: tag});
  endtask

  task automatic step(input logic [15:0] r, input logic [15:0] l,
                      input logic [1:0] tr, input logic [2:0] bu,
                      input logic rdy, input logic [1:0] rs, input logic [15:0] sp,
                      input logic [3:0] id, input logic ml, input string tag);
    @(negedge clk);
    apply(r, l, tr, bu, rdy, rs, sp, id, ml, tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: compares one queued expectation after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (sb.size() != 0) begin
      e = sb.pop_front();
      check(e.tag, e.id, e.ml);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset state", 4'd0, 1'b0);
    check("R1 reset grant one-hot", 4'd0, 1'b0);
    rst_n = 1'b1;
    // first edge after reset: no handover even with a request (R10)
    apply(16'h0008, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd0, 1'b0, "R10 start cycle");
    step(16'h0008, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd3, 1'b0, "R2 first grant");
    step(16'h0028, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd5, 1'b0, "R2 rotate to 5");
    step(16'h0028, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd3, 1'b0, "R2 wrap to 3");
    step(16'h0020, 16'h0, 2'b00, 3'b000, 1'b0, 2'b00, 16'h0, 4'd3, 1'b0, "R6 no ready hold");
    step(16'h0020, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd5, 1'b0, "R6 ready moves");
    step(16'h0028, 16'h0020, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd5, 1'b1, "R3 lock keeps");
    step(16'h0028, 16'h0020, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd5, 1'b1, "R5 lock flag");
    step(16'h0028, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd3, 1'b0, "R3 unlock releases");
    // 4-beat burst by master 3 with a stall (R7)
    step(16'h0028, 16'h0, 2'b10, 3'b010, 1'b1, 2'b00, 16'h0, 4'd3, 1'b0, "R7 beat1");
    step(16'h0028, 16'h0, 2'b11, 3'b010, 1'b1, 2'b00, 16'h0, 4'd3, 1'b0, "R7 beat2");
    step(16'h0028, 16'h0, 2'b11, 3'b010, 1'b0, 2'b00, 16'h0, 4'd3, 1'b0, "R7 stall");
    step(16'h0028, 16'h0, 2'b11, 3'b010, 1'b1, 2'b00, 16'h0, 4'd3, 1'b0, "R7 beat3");
    step(16'h0028, 16'h0, 2'b11, 3'b010, 1'b1, 2'b00, 16'h0, 4'd5, 1'b0, "R7 last beat");
    step(16'h0028, 16'h0, 2'b10, 3'b100, 1'b1, 2'b00, 16'h0, 4'd5, 1'b0, "R7 8-beat start");
    step(16'h0028, 16'h0, 2'b00, 3'b100, 1'b1, 2'b00, 16'h0, 4'd3, 1'b0, "R8 idle ends burst");
    // lock and SPLIT together on master 3 (R9)
    step(16'h0028, 16'h0008, 2'b00, 3'b000, 1'b1, 2'b11, 16'h0, 4'd5, 1'b0, "R9 split over lock");
    step(16'h0028, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd5, 1'b0, "R9 masked master");
    step(16'h0008, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd0, 1'b0, "R4 park while masked");
    step(16'h0008, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0008, 4'd3, 1'b0, "R9 resume same cycle");
    step(16'h0000, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd0, 1'b0, "R4 park idle");
    step(16'h8002, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd1, 1'b0, "R2 after park");
    step(16'h8002, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd15, 1'b0, "R2 top master");
    step(16'h8002, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd1, 1'b0, "R2 wrap 15 to 0");
    step(16'h8002, 16'h8000, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd15, 1'b1, "R5 lock at grant");
    step(16'h8002, 16'h8000, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd15, 1'b1, "R3 lock hold 15");
    step(16'h8002, 16'h0, 2'b00, 3'b000, 1'b1, 2'b00, 16'h0, 4'd1, 1'b0, "R1 R5 release");
    @(negedge clk);
    req = '0; lock = '0; htrans = 2'b00; hresp = 2'b00; hsplit = '0;
    repeat (3) @(negedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R1 scoreboard: left=%0d expected=0", sb.size());
    end
    done = 1'b1;
    summary();
  end
endmodule